// File: doc/BRIEF.md
# Decimal Adjust Unit

This block corrects the result of a binary add or subtract so that it reads as a decimal value. It works on a 16-bit accumulator held as a high byte and a low byte, using a carry flag and a half carry (auxiliary) flag that come in with the data. A 3-bit operation code picks one of six corrections. Two work on packed decimal, with two digits per byte. Two work on unpacked decimal, with one digit in the low nibble and a carry into the high byte. The remaining two prepare for or finish a byte multiply or divide in a selectable number base.

Each request is presented with a one-cycle valid strobe. The new accumulator and flags appear one clock later on registered outputs together with an output strobe. The outputs are carry, auxiliary carry, zero, sign, even parity and an error flag. The results stay on the outputs until the next request. The flags are not stored beyond the output register.

Top module: `bcd_adjust_unit`

## Requirements
- R1: A request sampled with `inValid` high at a rising clock edge sets `outValid` for exactly the following cycle, and the results appear on the outputs at that same edge. While `inValid` is low, all result outputs keep their values.
- R2: Opcode 0 (packed add correction). If the low nibble of the low byte is above 9 or `inAux` is set, add 6 to the low byte and set auxiliary carry. Then, if the original low byte is above 0x99 or `inCarry` is set, add 0x60 and set carry. Flags not set by a step are cleared.
- R3: Opcode 1 (packed subtract correction). If the low nibble is above 9 or `inAux` is set, set auxiliary carry, set carry when the original low byte is below 6 or `inCarry` is set, and subtract 6. Then, if the original low byte is above 0x99 or `inCarry` is set, subtract 0x60 and set carry.
- R4: Opcodes 0 and 1 leave the high byte unchanged. For every opcode, zero is set when the result low byte is 0 and sign copies bit 7 of the result low byte. Parity is 1 when the result low byte has an even number of one bits.
- R5: Opcode 2 (unpacked add correction). When the low nibble is above 9 or `inAux` is set, the low byte becomes the low nibble of (low + 6). The high byte increases by 1, and by 2 if the original low byte is above 0xF9. Carry and auxiliary carry are both set.
- R6: Opcode 3 (unpacked subtract correction). Under the same condition, the low byte becomes the low nibble of (low − 6). The high byte decreases by 1, and by 2 if the original low byte is below 6. Carry and auxiliary carry are both set.
- R7: For opcodes 2 and 3 when the condition is false, the high byte is kept, the low byte is reduced to its low nibble, and carry and auxiliary carry are cleared.
- R8: Opcode 4 (multiply correction) with a nonzero `inBase` sets the high byte to low / base and the low byte to low mod base. Carry, auxiliary carry and error are cleared.
- R9: Opcode 4 with `inBase` equal to 0 sets `outError`, leaves both bytes unchanged, and clears carry and auxiliary carry. `outError` is 0 for every other request.
- R10: Opcode 5 (divide preparation) sets the low byte to (high × base + low) truncated to 8 bits and the high byte to 0. Carry and auxiliary carry are cleared.
- R11: Opcodes 6 and 7 return both bytes unchanged and pass `inCarry` and `inAux` through to the carry and auxiliary outputs.
- R12: After reset, `outValid`, both bytes and all flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe |
| inOp | input | 3 | Operation code |
| inHigh | input | 8 | Accumulator high byte |
| inLow | input | 8 | Accumulator low byte |
| inCarry | input | 1 | Incoming carry flag |
| inAux | input | 1 | Incoming auxiliary carry flag |
| inBase | input | 8 | Number base for opcodes 4 and 5 |
| outValid | output | 1 | Result strobe, one cycle after the request |
| outHigh | output | 8 | Result high byte |
| outLow | output | 8 | Result low byte |
| outCarry | output | 1 | Result carry |
| outAux | output | 1 | Result auxiliary carry |
| outZero | output | 1 | Result low byte is zero |
| outSign | output | 1 | Bit 7 of result low byte |
| outParity | output | 1 | Result low byte has even parity |
| outError | output | 1 | Multiply correction with zero base |

## Verification
Every result is due exactly one rising edge after the request edge. This applies to the bytes, all six flags and the output strobe. The bench drives each request on a falling edge and holds `inValid` for one cycle. It then samples every output on the next falling edge, which is the midpoint of the cycle in which `outValid` must be high. The bench samples once more a cycle later to confirm that the strobe has dropped. It also confirms that the results are unchanged even though the inputs were altered with no strobe.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int OP_W   = 3;
  localparam int WIDE_W = 2 * BYTE_W;

  localparam logic [NIB_W-1:0]  NIB_MAX_DIGIT = NIB_W'(9);
  localparam logic [BYTE_W-1:0] LOW_FIX       = BYTE_W'(6);
  localparam logic [BYTE_W-1:0] HIGH_FIX      = BYTE_W'(8'h60);
  localparam logic [BYTE_W-1:0] PACKED_LIMIT  = BYTE_W'(8'h99);
  localparam logic [BYTE_W-1:0] UNPACK_WRAP   = BYTE_W'(8'hF9);

  typedef enum logic [OP_W-1:0] {
    OP_PACK_ADD  = 3'd0,
    OP_PACK_SUB  = 3'd1,
    OP_UNPK_ADD  = 3'd2,
    OP_UNPK_SUB  = 3'd3,
    OP_MUL_FIX   = 3'd4,
    OP_DIV_PREP  = 3'd5,
    OP_RSV_A     = 3'd6,
    OP_RSV_B     = 3'd7
  } adj_op_e;

  typedef struct packed {
    logic    capture;
    adj_op_e op;
    logic    zeroBase;
  } adj_ctrl_t;

endpackage

// File: rtl/bcd_adj_flags.sv
module bcd_adj_flags #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] value,
  output logic             isZero,
  output logic             isNeg,
  output logic             evenPar
);
  always_comb begin
    isZero  = (value == '0);
    isNeg   = value[WIDTH-1];
    evenPar = ~(^value);
  end
endmodule

// File: rtl/bcd_adj_ctrl.sv
module bcd_adj_ctrl
  import bcd_adj_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  input  logic [OP_W-1:0]    inOp,
  input  logic [BYTE_W-1:0]  inBase,
  output adj_ctrl_t          ctrl,
  output logic               validQ
);
  always_comb begin
    ctrl.capture  = inValid;
    ctrl.op       = adj_op_e'(inOp);
    ctrl.zeroBase = (inBase == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) validQ <= 1'b0;
    else        validQ <= inValid;
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    validQ && !$past(inValid) |-> 1'b0) else $error("strobe without request"); // R1
endmodule

// File: rtl/bcd_adj_dpath.sv
module bcd_adj_dpath
  import bcd_adj_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  adj_ctrl_t          ctrl,
  input  logic [BYTE_W-1:0]  inHigh,
  input  logic [BYTE_W-1:0]  inLow,
  input  logic               inCarry,
  input  logic               inAux,
  input  logic [BYTE_W-1:0]  inBase,
  output logic [BYTE_W-1:0]  highQ,
  output logic [BYTE_W-1:0]  lowQ,
  output logic               carryQ,
  output logic               auxQ,
  output logic               zeroQ,
  output logic               signQ,
  output logic               parityQ,
  output logic               errorQ
);
  logic [BYTE_W-1:0] nextHigh, nextLow;
  logic              nextCarry, nextAux, nextErr;
  logic              fZero, fSign, fPar;
  logic              nibbleHit, packedHit;
  logic [BYTE_W-1:0] stepLow;
  logic [WIDE_W-1:0] mulSum;

  always_comb begin
    nibbleHit = (inLow[NIB_W-1:0] > NIB_MAX_DIGIT) || inAux;
    packedHit = (inLow > PACKED_LIMIT) || inCarry;
    mulSum    = WIDE_W'(inHigh) * WIDE_W'(inBase) + WIDE_W'(inLow);
    stepLow   = inLow;
    nextHigh  = inHigh;
    nextLow   = inLow;
    nextCarry = 1'b0;
    nextAux   = 1'b0;
    nextErr   = 1'b0;
    unique case (ctrl.op)
      OP_PACK_ADD: begin
        if (nibbleHit) begin
          stepLow = inLow + LOW_FIX;
          nextAux = 1'b1;
        end
        if (packedHit) begin
          stepLow   = stepLow + HIGH_FIX;
          nextCarry = 1'b1;
        end
        nextLow = stepLow;
      end
      OP_PACK_SUB: begin
        if (nibbleHit) begin
          nextAux = 1'b1;
          if ((inLow < LOW_FIX) || inCarry) nextCarry = 1'b1;
          stepLow = inLow - LOW_FIX;
        end
        if (packedHit) begin
          stepLow   = stepLow - HIGH_FIX;
          nextCarry = 1'b1;
        end
        nextLow = stepLow;
      end
      OP_UNPK_ADD: begin
        if (nibbleHit) begin
          stepLow   = inLow + LOW_FIX;
          nextLow   = {{NIB_W{1'b0}}, stepLow[NIB_W-1:0]};
          nextHigh  = inHigh + BYTE_W'(1) + BYTE_W'(inLow > UNPACK_WRAP);
          nextCarry = 1'b1;
          nextAux   = 1'b1;
        end else begin
          nextLow = {{NIB_W{1'b0}}, inLow[NIB_W-1:0]};
        end
      end
      OP_UNPK_SUB: begin
        if (nibbleHit) begin
          stepLow   = inLow - LOW_FIX;
          nextLow   = {{NIB_W{1'b0}}, stepLow[NIB_W-1:0]};
          nextHigh  = inHigh - BYTE_W'(1) - BYTE_W'(inLow < LOW_FIX);
          nextCarry = 1'b1;
          nextAux   = 1'b1;
        end else begin
          nextLow = {{NIB_W{1'b0}}, inLow[NIB_W-1:0]};
        end
      end
      OP_MUL_FIX: begin
        if (ctrl.zeroBase) begin
          nextErr = 1'b1;
        end else begin
          nextHigh = inLow / inBase;
          nextLow  = inLow % inBase;
        end
      end
      OP_DIV_PREP: begin
        nextLow  = mulSum[BYTE_W-1:0];
        nextHigh = '0;
      end
      default: begin
        nextCarry = inCarry;
        nextAux   = inAux;
      end
    endcase
  end

  bcd_adj_flags #(.WIDTH(BYTE_W)) flags_i (
    .value   (nextLow),
    .isZero  (fZero),
    .isNeg   (fSign),
    .evenPar (fPar)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      highQ   <= '0;
      lowQ    <= '0;
      carryQ  <= 1'b0;
      auxQ    <= 1'b0;
      zeroQ   <= 1'b0;
      signQ   <= 1'b0;
      parityQ <= 1'b0;
      errorQ  <= 1'b0;
    end else if (ctrl.capture) begin
      highQ   <= nextHigh;
      lowQ    <= nextLow;
      carryQ  <= nextCarry;
      auxQ    <= nextAux;
      zeroQ   <= fZero;
      signQ   <= fSign;
      parityQ <= fPar;
      errorQ  <= nextErr;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.capture |=> $stable(highQ) && $stable(lowQ) && $stable(carryQ) && $stable(errorQ))
    else $error("result moved without request"); // R1
  AST_UNPACK_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.capture && (ctrl.op == OP_UNPK_ADD || ctrl.op == OP_UNPK_SUB) |=> lowQ[BYTE_W-1:NIB_W] == '0)
    else $error("unpacked low byte has upper nibble"); // R5
  AST_UNPACK_FLAGS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.capture && (ctrl.op == OP_UNPK_ADD || ctrl.op == OP_UNPK_SUB) |=> carryQ == auxQ)
    else $error("unpacked carry and aux differ"); // R7
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
  import bcd_adj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [2:0]        inOp,
  input  logic [7:0]        inHigh,
  input  logic [7:0]        inLow,
  input  logic              inCarry,
  input  logic              inAux,
  input  logic [7:0]        inBase,
  output logic              outValid,
  output logic [7:0]        outHigh,
  output logic [7:0]        outLow,
  output logic              outCarry,
  output logic              outAux,
  output logic              outZero,
  output logic              outSign,
  output logic              outParity,
  output logic              outError
);
  adj_ctrl_t ctrl;

  bcd_adj_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .inOp    (inOp),
    .inBase  (inBase),
    .ctrl    (ctrl),
    .validQ  (outValid)
  );

  bcd_adj_dpath dpath_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl),
    .inHigh  (inHigh),
    .inLow   (inLow),
    .inCarry (inCarry),
    .inAux   (inAux),
    .inBase  (inBase),
    .highQ   (outHigh),
    .lowQ    (outLow),
    .carryQ  (outCarry),
    .auxQ    (outAux),
    .zeroQ   (outZero),
    .signQ   (outSign),
    .parityQ (outParity),
    .errorQ  (outError)
  );

  AST_RESULT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid) else $error("missing result strobe"); // R1
  AST_PACKED_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && (inOp == OP_PACK_ADD || inOp == OP_PACK_SUB) |=> outHigh == $past(inHigh))
    else $error("packed correction changed high byte"); // R4
  AST_ZERO_BASE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inOp == OP_MUL_FIX && inBase == 8'd0 |=>
      outError && outHigh == $past(inHigh) && outLow == $past(inLow))
    else $error("zero base not flagged"); // R9
  AST_ERR_ONLY_ZERO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && !(inOp == OP_MUL_FIX && inBase == 8'd0) |=> !outError)
    else $error("spurious error"); // R9
  AST_DIVPREP_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inOp == OP_DIV_PREP |=> outHigh == 8'd0)
    else $error("divide preparation left high byte"); // R10
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> outZero == (outLow == 8'd0)) else $error("zero flag mismatch"); // R4
endmodule

// File: tb/bcd_adjust_unit_tb_top.sv
module bcd_adjust_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [2:0] inOp = '0;
  logic [7:0] inHigh = '0, inLow = '0, inBase = '0;
  logic inCarry = 1'b0, inAux = 1'b0;
  logic outValid, outCarry, outAux, outZero, outSign, outParity, outError;
  logic [7:0] outHigh, outLow;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bcd_adjust_unit dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inOp(inOp),
    .inHigh(inHigh), .inLow(inLow), .inCarry(inCarry), .inAux(inAux),
    .inBase(inBase), .outValid(outValid), .outHigh(outHigh), .outLow(outLow),
    .outCarry(outCarry), .outAux(outAux), .outZero(outZero), .outSign(outSign),
    .outParity(outParity), .outError(outError)
  );

  typedef struct packed {
    logic [7:0] hi;
    logic [7:0] lo;
    logic c, a, z, s, p, e;
  } res_t;

  function automatic res_t model(input logic [2:0] op, input logic [7:0] hi, input logic [7:0] lo,
                                 input logic c, input logic a, input logic [7:0] base);
    res_t r;
    logic [7:0] t;
    logic [15:0] w;
    r = '0;
    r.hi = hi; r.lo = lo;
    case (op)
      3'd0: begin
        t = lo;
        if (lo[3:0] > 4'd9 || a) begin t = t + 8'd6; r.a = 1'b1; end
        if (lo > 8'h99 || c) begin t = t + 8'h60; r.c = 1'b1; end
        r.lo = t;
      end
      3'd1: begin
        t = lo;
        if (lo[3:0] > 4'd9 || a) begin
          r.a = 1'b1;
          if (lo < 8'd6 || c) r.c = 1'b1;
          t = t - 8'd6;
        end
        if (lo > 8'h99 || c) begin t = t - 8'h60; r.c = 1'b1; end
        r.lo = t;
      end
      3'd2, 3'd3: begin
        if (lo[3:0] > 4'd9 || a) begin
          t = (op == 3'd2) ? lo + 8'd6 : lo - 8'd6;
          r.lo = {4'd0, t[3:0]};
          if (op == 3'd2) r.hi = hi + 8'd1 + ((lo > 8'hF9) ? 8'd1 : 8'd0);
          else            r.hi = hi - 8'd1 - ((lo < 8'd6) ? 8'd1 : 8'd0);
          r.c = 1'b1; r.a = 1'b1;
        end else begin
          r.lo = {4'd0, lo[3:0]};
        end
      end
      3'd4: begin
        if (base == 8'd0) r.e = 1'b1;
        else begin r.hi = lo / base; r.lo = lo % base; end
      end
      3'd5: begin
        w = 16'(hi) * 16'(base) + 16'(lo);
        r.lo = w[7:0]; r.hi = 8'd0;
      end
      default: begin r.c = c; r.a = a; end
    endcase
    r.z = (r.lo == 8'd0);
    r.s = r.lo[7];
    r.p = ~(^r.lo);
    return r;
  endfunction

  function automatic res_t actual();
    return {outHigh, outLow, outCarry, outAux, outZero, outSign, outParity, outError};
  endfunction

  task automatic check_res(input string tag, input res_t exp);
    res_t act;
    act = actual();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual hi=%h lo=%h c=%b a=%b z=%b s=%b p=%b e=%b expected hi=%h lo=%h c=%b a=%b z=%b s=%b p=%b e=%b",
        tag, act.hi, act.lo, act.c, act.a, act.z, act.s, act.p, act.e,
        exp.hi, exp.lo, exp.c, exp.a, exp.z, exp.s, exp.p, exp.e);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // drive one request at a falling edge, sample at the next falling edge
  task automatic issue(input logic [2:0] op, input logic [7:0] hi, input logic [7:0] lo,
                       input logic c, input logic a, input logic [7:0] base);
    @(negedge clk);
    inOp = op; inHigh = hi; inLow = lo; inCarry = c; inAux = a; inBase = base;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic run_op(input string tag, input logic [2:0] op, input logic [7:0] hi,
                        input logic [7:0] lo, input logic c, input logic a, input logic [7:0] base);
    issue(op, hi, lo, c, a, base);
    check_res(tag, model(op, hi, lo, c, a, base));
  endtask

  task automatic test_reset();
    check_res("R12 reset state", '0);
    check_bit("R12 reset outValid", outValid, 1'b0);
  endtask

  task automatic test_latency_hold();
    res_t held;
    issue(3'd0, 8'h12, 8'h3C, 1'b0, 1'b0, 8'd0);
    check_bit("R1 strobe one cycle after request", outValid, 1'b1);
    held = actual();
    inOp = 3'd5; inHigh = 8'hAA; inLow = 8'h55; inBase = 8'd3; inCarry = 1'b1;
    @(negedge clk);
    check_bit("R1 strobe drops", outValid, 1'b0);
    check_res("R1 outputs hold without strobe", held);
  endtask

  task automatic test_packed_add();
    run_op("R2 packed add wrap 0x9A", 3'd0, 8'h33, 8'h9A, 1'b0, 1'b0, 8'd0);
    check_res("R2 literal 0x9A to 00", '{hi:8'h33, lo:8'h00, c:1'b1, a:1'b1, z:1'b1, s:1'b0, p:1'b1, e:1'b0});
    run_op("R2 packed add aux only", 3'd0, 8'h00, 8'h41, 1'b0, 1'b1, 8'd0);
    run_op("R2 packed add carry only", 3'd0, 8'h07, 8'h25, 1'b1, 1'b0, 8'd0);
    run_op("R2 packed add no fix", 3'd0, 8'h01, 8'h58, 1'b0, 1'b0, 8'd0);
    run_op("R4 packed add sign and parity", 3'd0, 8'hF0, 8'h7B, 1'b0, 1'b0, 8'd0);
  endtask

  task automatic test_packed_sub();
    run_op("R3 packed sub borrow chain", 3'd1, 8'h44, 8'h00, 1'b1, 1'b1, 8'd0);
    check_res("R3 literal 00 to 9A", '{hi:8'h44, lo:8'h9A, c:1'b1, a:1'b1, z:1'b0, s:1'b1, p:1'b1, e:1'b0});
    run_op("R3 packed sub low below 6", 3'd1, 8'h00, 8'h03, 1'b0, 1'b1, 8'd0);
    run_op("R3 packed sub above 0x99", 3'd1, 8'h10, 8'hAF, 1'b0, 1'b0, 8'd0);
    run_op("R3 packed sub no fix", 3'd1, 8'h20, 8'h42, 1'b0, 1'b0, 8'd0);
  endtask

  task automatic test_unpacked();
    run_op("R5 unpacked add wrap 0xFA", 3'd2, 8'h05, 8'hFA, 1'b0, 1'b0, 8'd0);
    check_res("R5 literal double increment", '{hi:8'h07, lo:8'h00, c:1'b1, a:1'b1, z:1'b1, s:1'b0, p:1'b1, e:1'b0});
    run_op("R5 unpacked add aux set", 3'd2, 8'hFF, 8'h09, 1'b0, 1'b1, 8'd0);
    run_op("R6 unpacked sub below 6", 3'd3, 8'h10, 8'h03, 1'b0, 1'b1, 8'd0);
    check_res("R6 literal double decrement", '{hi:8'h0E, lo:8'h0D, c:1'b1, a:1'b1, z:1'b0, s:1'b0, p:1'b0, e:1'b0});
    run_op("R6 unpacked sub nibble hit", 3'd3, 8'h00, 8'h2C, 1'b0, 1'b0, 8'd0);
    run_op("R7 unpacked add no fix", 3'd2, 8'h21, 8'h35, 1'b1, 1'b0, 8'd0);
    check_res("R7 literal mask", '{hi:8'h21, lo:8'h05, c:1'b0, a:1'b0, z:1'b0, s:1'b0, p:1'b1, e:1'b0});
    run_op("R7 unpacked sub no fix", 3'd3, 8'h09, 8'hF0, 1'b1, 1'b0, 8'd0);
  endtask

  task automatic test_mul_div();
    run_op("R8 multiply fix base 10", 3'd4, 8'hEE, 8'h4F, 1'b1, 1'b1, 8'd10);
    check_res("R8 literal 79 to 7,9", '{hi:8'h07, lo:8'h09, c:1'b0, a:1'b0, z:1'b0, s:1'b0, p:1'b1, e:1'b0});
    run_op("R8 multiply fix base 16", 3'd4, 8'h00, 8'hC3, 1'b0, 1'b0, 8'd16);
    run_op("R8 multiply fix base 255", 3'd4, 8'h00, 8'hFF, 1'b0, 1'b0, 8'd255);
    run_op("R9 zero base", 3'd4, 8'h5A, 8'hA5, 1'b1, 1'b1, 8'd0);
    check_res("R9 literal unchanged with error", '{hi:8'h5A, lo:8'hA5, c:1'b0, a:1'b0, z:1'b0, s:1'b1, p:1'b1, e:1'b1});
    run_op("R9 error clears on next request", 3'd0, 8'h00, 8'h11, 1'b0, 1'b0, 8'd0);
    run_op("R10 divide prep base 10", 3'd5, 8'h07, 8'h09, 1'b1, 1'b0, 8'd10);
    check_res("R10 literal 79", '{hi:8'h00, lo:8'h4F, c:1'b0, a:1'b0, z:1'b0, s:1'b0, p:1'b0, e:1'b0});
    run_op("R10 divide prep truncation", 3'd5, 8'hFF, 8'hFF, 1'b0, 1'b1, 8'hFF);
    run_op("R10 divide prep zero base", 3'd5, 8'h33, 8'h80, 1'b0, 1'b0, 8'd0);
  endtask

  task automatic test_reserved();
    run_op("R11 opcode 6 pass", 3'd6, 8'h12, 8'h34, 1'b1, 1'b0, 8'd9);
    run_op("R11 opcode 7 pass", 3'd7, 8'hAB, 8'h00, 1'b0, 1'b1, 8'd0);
  endtask

  task automatic test_sweep();
    for (int i = 0; i < 256; i += 7) begin
      for (int op = 0; op < 6; op++) begin
        run_op($sformatf("R2 R3 R5 R6 R8 R10 sweep op%0d low %0d", op, i), 3'(op),
               8'(i * 3), 8'(i), i[0], i[1], 8'(i % 13));
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_latency_hold();
    test_packed_add();
    test_packed_sub();
    test_unpacked();
    test_mul_div();
    test_reserved();
    test_sweep();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule